// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block is the digital front end of a PLL. It holds one 32-bit control word that sets the PLL's feedback multiplier, its pre-divider, its enable and its bypass select. The word also reports the PLL's lock state. Software can write the word directly while the block is idle.

A multiplier change can also be requested through a dedicated request port. The block then runs a fixed hardware sequence so that the PLL output is never used while it is unsettled:

- Bypass is forced first.
- The multiplier is written and the pre-divider is set to 1.
- If the PLL is enabled, the block polls the lock signal once per microsecond tick, up to a bounded number of polls.
- Bypass is released last.

The lock signal comes from an analog PLL model and is asynchronous to the block clock. It is synchronized through two flops before it is used.

The sense of the bypass bit is a per-instance parameter. When the bit is inverted, a stored 0 selects bypass. The decoded bypass status always uses the instance's own polarity.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset the control word reads multiplier 1 (bits 31:16), pre-divider 1 (bits 15:8), lock 0 (bit 7), enable 0 (bit 3), bypass asserted (bit 2, in the instance's polarity) and lock-control 0 (bit 0). `busy` and all three error flags are low.
- R2: A write while idle updates bits 31:16, 15:8, 3, 2 and 0 on the next clock. Bits 6:4 and 1 read as 0. Bit 7 shows the lock input two clocks after it changes.
- R3: A valid request accepted while idle raises `busy` on the next clock. Bypass is asserted one clock later. One clock after that, the multiplier becomes the requested value, the pre-divider becomes 1 and lock-control becomes 0.
- R4: With enable clear, bypass is released and `busy` drops on the clock after the fields are rewritten.
- R5: With enable set, the block samples the synchronized lock on each microsecond tick. The first tick that sees lock ends the wait. Bypass is then released without an error.
- R6: If LOCK_TRIES ticks pass without lock, `err_timeout` is set and stays set. Bypass is still released and `busy` drops.
- R7: A request that arrives while `busy` is high is dropped and sets the sticky `err_busy`.
- R8: A request of 0, or of more than 0xFFFF, is rejected while idle. It sets the sticky `err_range` and leaves the control word and `busy` unchanged.
- R9: Register writes while `busy` is high have no effect.
- R10: With INV_BYPASS=1, a stored bypass bit of 0 means bypass. `bypass_active` and the `pll_bypass` pin follow that polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write value |
| rd_data | output | 32 | Control word read value |
| req_valid | input | 1 | Reprogramming request strobe |
| req_mult | input | 17 | Requested multiplier |
| pll_lock_async | input | 1 | Lock indication from the PLL, asynchronous |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| pll_mult | output | 16 | Multiplier driven to the PLL |
| pll_prediv | output | 8 | Pre-divider driven to the PLL |
| pll_enable | output | 1 | PLL enable |
| pll_bypass | output | 1 | Stored bypass bit, in the instance's polarity |
| bypass_active | output | 1 | High when the output is the bypass clock |
| busy | output | 1 | Sequence in progress |
| err_timeout | output | 1 | Sticky lock timeout |
| err_busy | output | 1 | Sticky dropped-request flag |
| err_range | output | 1 | Sticky rejected-request flag |

## Verification
Results become visible at fixed offsets, counted from the clock edge that accepts a request:

| Result | Clock edges after acceptance |
|---|---|
| `busy` high | 1 |
| bypass asserted | 2 |
| fields rewritten | 3 |
| bypass released (enable clear) | 4 |

A write shows in the read value one edge after the write. The lock bit follows two edges after the lock input changes.

The driver pushes each expected value for the negative edge at which it falls due, and the monitor compares it there. Lock waits depend on when ticks fall, so those checks bound the wait with a cycle budget. Before the timeout is due, the bench confirms that `busy` is still high and no error has been raised. After `busy` falls, it checks the outcome.

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq #(
  parameter bit INV_BYPASS = 1'b0,
  parameter int LOCK_TRIES = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic        req_valid,
  input  logic [16:0] req_mult,
  input  logic        pll_lock_async,
  input  logic        us_tick,
  output logic [15:0] pll_mult,
  output logic [7:0]  pll_prediv,
  output logic        pll_enable,
  output logic        pll_bypass,
  output logic        bypass_active,
  output logic        busy,
  output logic        err_timeout,
  output logic        err_busy,
  output logic        err_range
);
  localparam int CW = $clog2(LOCK_TRIES + 1);

  typedef enum logic [2:0] {S_IDLE, S_BYP, S_LOAD, S_WAIT, S_REL} st_t;

  st_t         st;
  logic [15:0] mult_q, pend_q;
  logic [7:0]  div_q;
  logic        en_q, bp_q, lc_q;
  logic        lk_m, lk_s;
  logic [CW-1:0] cnt;

  wire req_bad = (req_mult == 17'd0) || req_mult[16];
  wire go      = req_valid && (st == S_IDLE) && !req_bad;

  assign busy          = (st != S_IDLE);
  assign bypass_active = bp_q ^ INV_BYPASS;
  assign pll_bypass    = bp_q;
  assign pll_mult      = mult_q;
  assign pll_prediv    = div_q;
  assign pll_enable    = en_q;
  assign rd_data       = {mult_q, div_q, lk_s, 3'b000, en_q, bp_q, 1'b0, lc_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_m <= 1'b0;
      lk_s <= 1'b0;
    end else begin
      lk_m <= pll_lock_async;
      lk_s <= lk_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      mult_q      <= 16'd1;
      pend_q      <= 16'd1;
      div_q       <= 8'd1;
      en_q        <= 1'b0;
      bp_q        <= ~INV_BYPASS;
      lc_q        <= 1'b0;
      cnt         <= '0;
      err_timeout <= 1'b0;
      err_busy    <= 1'b0;
      err_range   <= 1'b0;
    end else begin
      if (req_valid && busy) err_busy <= 1'b1;
      if (req_valid && !busy && req_bad) err_range <= 1'b1;
      case (st)
        S_IDLE: begin
          if (go) begin
            pend_q <= req_mult[15:0];
            st     <= S_BYP;
          end else if (wr_en) begin
            mult_q <= wr_data[31:16];
            div_q  <= wr_data[15:8];
            en_q   <= wr_data[3];
            bp_q   <= wr_data[2];
            lc_q   <= wr_data[0];
          end
        end
        S_BYP: begin
          bp_q <= ~INV_BYPASS;
          st   <= S_LOAD;
        end
        S_LOAD: begin
          mult_q <= pend_q;
          div_q  <= 8'd1;
          lc_q   <= 1'b0;
          cnt    <= '0;
          st     <= en_q ? S_WAIT : S_REL;
        end
        S_WAIT: begin
          if (us_tick) begin
            if (lk_s) st <= S_REL;
            else if (cnt == CW'(LOCK_TRIES - 1)) begin
              err_timeout <= 1'b1;
              st          <= S_REL;
            end else cnt <= cnt + 1'b1;
          end
        end
        S_REL: begin
          bp_q <= INV_BYPASS;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R3
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && !req_bad) |=> busy);

  // R3
  wait_in_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT || st == S_LOAD) |-> bypass_active);

  // R6
  timeout_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_timeout) |=> (!busy && !bypass_active));

  // R7
  drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && busy) |=> err_busy);

  // R8
  reject_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && req_bad) |=> (!busy && err_range && $stable(mult_q)));

  // R9
  write_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && st != S_LOAD && st != S_BYP && st != S_REL) |=> $stable(en_q));
endmodule

// File: tb/pll_reprog_seq_test.sv
`timescale 1ns/1ps
module pll_reprog_seq_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, wr_en, req_valid, lock_a, tick;
  logic [31:0] wr_data;
  logic [16:0] req_mult;
  logic [31:0] rd_a, rd_b;
  logic [15:0] m_a, m_b;
  logic [7:0]  p_a, p_b;
  logic        en_a, en_b, bpr_a, bpr_b, ba_a, ba_b, bz_a, bz_b;
  logic        et_a, et_b, eb_a, eb_b, er_a, er_b;

  pll_reprog_seq #(.INV_BYPASS(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_a),
    .req_valid(req_valid), .req_mult(req_mult), .pll_lock_async(lock_a), .us_tick(tick),
    .pll_mult(m_a), .pll_prediv(p_a), .pll_enable(en_a), .pll_bypass(bpr_a),
    .bypass_active(ba_a), .busy(bz_a), .err_timeout(et_a), .err_busy(eb_a), .err_range(er_a));

  pll_reprog_seq #(.INV_BYPASS(1'b1)) uut_inv (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_b),
    .req_valid(req_valid), .req_mult(req_mult), .pll_lock_async(lock_a), .us_tick(tick),
    .pll_mult(m_b), .pll_prediv(p_b), .pll_enable(en_b), .pll_bypass(bpr_b),
    .bypass_active(ba_b), .busy(bz_b), .err_timeout(et_b), .err_busy(eb_b), .err_range(er_b));

  typedef struct { int sel; logic [31:0] exp; string req; } item_t;
  item_t q[$];
  event  do_chk;
  int    n_chk = 0, n_fail = 0;
  bit    done = 0;

  function automatic logic [31:0] obs(int sel);
    case (sel)
      0: return rd_a;
      1: return {31'd0, bz_a};
      2: return {31'd0, ba_a};
      3: return {31'd0, et_a};
      4: return {31'd0, eb_a};
      5: return {31'd0, er_a};
      6: return {31'd0, ba_b};
      7: return {31'd0, bpr_b};
      default: return rd_b;
    endcase
  endfunction

  initial forever begin
    @do_chk;
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] got;
      it  = q.pop_front();
      got = obs(it.sel);
      n_chk++;
      if (got !== it.exp) begin
        n_fail++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, got, it.exp);
      end
    end
  end

  task automatic expect_v(int sel, logic [31:0] e, string r);
    item_t it;
    it.sel = sel; it.exp = e; it.req = r;
    q.push_back(it);
  endtask

  task automatic check_now();
    ->do_chk;
    wait (q.size() == 0);
  endtask

  initial begin
    tick = 1'b0;
    forever begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic req(logic [16:0] m);
    req_valid = 1'b1; req_mult = m;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle(int lim);
    for (int i = 0; i < lim && bz_a; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; req_valid = 1'b0; req_mult = '0; lock_a = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    expect_v(0, 32'h0001_0104, "R1");
    expect_v(1, 0, "R1"); expect_v(3, 0, "R1"); expect_v(4, 0, "R1"); expect_v(5, 0, "R1");
    expect_v(2, 1, "R1"); expect_v(6, 1, "R1 R10"); expect_v(7, 0, "R1 R10");
    expect_v(8, 32'h0001_0100, "R10");
    check_now();

    // R2 direct write, bypass raw 0
    wr(32'h0005_02F1);
    expect_v(0, 32'h0005_0201, "R2");
    expect_v(2, 0, "R2");
    expect_v(6, 1, "R10");
    check_now();
    lock_a = 1'b1;
    cyc(1);
    expect_v(0, 32'h0005_0201, "R2");
    check_now();
    cyc(1);
    expect_v(0, 32'h0005_0281, "R2");
    check_now();

    // R3 R4 request with enable clear
    req(17'd40);
    expect_v(1, 1, "R3"); expect_v(2, 0, "R3");
    check_now();
    cyc(1);
    expect_v(2, 1, "R3"); expect_v(0, 32'h0005_0285, "R3");
    check_now();
    cyc(1);
    expect_v(0, 32'h0028_0184, "R3"); expect_v(1, 1, "R3");
    check_now();
    cyc(1);
    expect_v(1, 0, "R4"); expect_v(2, 0, "R4"); expect_v(0, 32'h0028_0180, "R4");
    expect_v(7, 1, "R10"); expect_v(6, 0, "R10");
    check_now();

    // R5 lock already present
    wr(32'h0028_0008);
    expect_v(0, 32'h0028_0088, "R2");
    check_now();
    req(17'd100);
    wait_idle(40);
    expect_v(1, 0, "R5"); expect_v(3, 0, "R5"); expect_v(2, 0, "R5");
    expect_v(0, 32'h0064_0188, "R5");
    check_now();

    // R5 lock arrives late
    lock_a = 1'b0;
    cyc(3);
    req(17'd200);
    cyc(300);
    expect_v(1, 1, "R5"); expect_v(2, 1, "R5");
    check_now();
    lock_a = 1'b1;
    wait_idle(40);
    expect_v(1, 0, "R5"); expect_v(3, 0, "R5"); expect_v(0, 32'h00C8_0188, "R5");
    check_now();

    // R6 R7 R9 timeout path
    lock_a = 1'b0;
    cyc(3);
    req(17'd300);
    cyc(4);
    req(17'd77);
    expect_v(4, 1, "R7");
    check_now();
    wr(32'h0000_0000);
    cyc(1900);
    expect_v(1, 1, "R6"); expect_v(3, 0, "R6");
    check_now();
    wait_idle(400);
    expect_v(1, 0, "R6"); expect_v(3, 1, "R6"); expect_v(2, 0, "R6");
    expect_v(0, 32'h012C_0108, "R9");
    check_now();

    // R8 range rejects
    req(17'd0);
    expect_v(5, 1, "R8"); expect_v(1, 0, "R8"); expect_v(0, 32'h012C_0108, "R8");
    check_now();
    req(17'h10000);
    cyc(1);
    expect_v(1, 0, "R8"); expect_v(0, 32'h012C_0108, "R8"); expect_v(2, 0, "R8");
    check_now();

    done = 1;
    finish_run();
  end
endmodule